// File: doc/BRIEF.md
# PCI Target Window Mapper

This block sits behind the pin-level logic of a PCI target. Each request it receives carries a command code, a one-hot vector of base-address-register hits and the offset inside the hit window. The block decides whether the target claims the request. A claimed request then becomes one of two things: a data request relocated onto the on-chip bus, or an access to the block's own small register file.

Windows 1 to 4 are data windows. Each of them has its own relocation register, which supplies the on-chip address bits above the window size. Window 0 opens the local register file: the relocation registers and an interrupt mask. Window 5 belongs to the chip's own master side, so the block never claims it. Configuration reads and writes are answered locally. They hold the memory-space enable, which gates every memory command.

A separate register port gives system software the same register file. Every decision is registered, so the block's outputs show the result one clock after the request is presented.

Top module: `pci_bar_mapper`

## Requirements
- R1: After reset the memory-space enable is 0, every relocation register and the interrupt mask read 0, and claim, fwd_valid and loc_rvalid are low.
- R2: While the memory-space enable is 0, a memory command (codes 0x6, 0x7, 0xC) is not claimed, is not forwarded and changes no register.
- R3: With the enable set, a memory read (0x6), memory read multiple (0xC) or memory write (0x7) that hits exactly one of windows 1 to 4 raises claim and fwd_valid for one cycle, one clock after the request. fwd_write is 1 only for code 0x7.
- R4: The forwarded address is the hit window's relocation register placed above bit WIN_LOG2, concatenated with the request offset bits below WIN_LOG2.
- R5: Any other command code, for example 0x2, 0x3, 0xE, 0x0 or 0xF, is not claimed, is not forwarded and changes no register.
- R6: A memory command that hits window 0 (req_bar bit 0) is claimed and never forwarded. The word index is offset bits [4:2]: indexes 1 to 4 select relocation registers 1 to 4, and index 5 selects the interrupt mask. A write updates the selected register. A read returns its value on loc_rdata, with loc_rvalid high, one clock later.
- R7: A request whose only hit is window 5 (req_bar = 6'b100000) is never claimed and never forwarded.
- R8: Configuration read (0xA) and configuration write (0xB) are claimed regardless of the enable and never forwarded. Dword offset 1 (byte offset 0x04) holds the memory-space enable in bit 1. A read of any other offset returns 0.
- R9: The register port reads the selected register combinationally on host_rdata. host_we writes it at the clock edge, and only the bits above WIN_LOG2 of a relocation register are stored.
- R10: When the register port and a window-0 write target the same register in the same cycle, the register port's value is stored. Writes to different registers in the same cycle both land.
- R11: A request with more than one hit bit set in req_bar is not claimed and not forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | PCI command code |
| req_bar | input | 6 | One-hot window hit vector, bit i = window i |
| req_offs | input | WIN_LOG2 | Byte offset inside the hit window |
| req_wdata | input | WIDTH | Write data for local writes |
| host_we | input | 1 | Register port write strobe |
| host_idx | input | IDX_W | Register port word index |
| host_wdata | input | WIDTH | Register port write data |
| host_rdata | output | WIDTH | Register port read data |
| claim | output | 1 | Target claims the request (device select) |
| fwd_valid | output | 1 | One-cycle strobe for a relocated on-chip request |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_addr | output | WIDTH | Relocated on-chip address |
| loc_rvalid | output | 1 | Local read data valid |
| loc_rdata | output | WIDTH | Local read data |

## Verification
The register port and a window-0 write can both update the register file in the same clock. The bench provokes this by presenting a window-0 write and a register-port write on the same falling edge, once to the same relocation register and once to two different ones. It judges the result through host_rdata and through the address of a later forwarded request. A relocation change made through window 0 and used by the very next data request is also checked, to show that the new mapping takes effect on the following cycle.

// File: rtl/pcibm_pkg.sv
package pcibm_pkg;

   localparam int NUM_WIN = 6;

   localparam logic [3:0] CMD_MEM_RD  = 4'h6;
   localparam logic [3:0] CMD_MEM_WR  = 4'h7;
   localparam logic [3:0] CMD_MEM_RDM = 4'hC;
   localparam logic [3:0] CMD_CFG_RD  = 4'hA;
   localparam logic [3:0] CMD_CFG_WR  = 4'hB;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_FWD   = 2'd1,
      ACC_LOCAL = 2'd2,
      ACC_CFG   = 2'd3
   } acc_kind_e;

   function automatic logic is_mem_cmd(input logic [3:0] c);
      return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM);
   endfunction

   function automatic logic is_cfg_cmd(input logic [3:0] c);
      return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
   endfunction

endpackage

// File: rtl/pcibm_decode.sv
module pcibm_decode
   import pcibm_pkg::*;
#(
   parameter int NUM_DATA_BARS = 4
) (
   input  logic              req_valid,
   input  logic [3:0]        req_cmd,
   input  logic [NUM_WIN-1:0] req_bar,
   input  logic              mem_en,
   output acc_kind_e         kind,
   output logic [2:0]        bar_idx,
   output logic              is_wr
);

   logic [2:0] hit_idx;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (req_bar[i]) hit_idx = 3'(i);
      end
   end

   always_comb begin
      kind    = ACC_NONE;
      bar_idx = hit_idx;
      is_wr   = (req_cmd == CMD_MEM_WR) || (req_cmd == CMD_CFG_WR);
      if (req_valid) begin
         if (is_cfg_cmd(req_cmd)) begin
            kind = ACC_CFG;
         end else if (is_mem_cmd(req_cmd) && mem_en && $onehot(req_bar)) begin
            if (hit_idx == 3'd0)
               kind = ACC_LOCAL;
            else if (int'(hit_idx) <= NUM_DATA_BARS)
               kind = ACC_FWD;
         end
      end
   end

endmodule

// File: rtl/pcibm_regfile.sv
module pcibm_regfile #(
   parameter int WIDTH         = 32,
   parameter int WIN_LOG2      = 16,
   parameter int NUM_DATA_BARS = 4,
   parameter int IDX_W         = 3,
   localparam int MAP_W        = WIDTH - WIN_LOG2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              host_we,
   input  logic [IDX_W-1:0]                  host_idx,
   input  logic [WIDTH-1:0]                  host_wdata,
   output logic [WIDTH-1:0]                  host_rdata,
   input  logic                              pci_we,
   input  logic [IDX_W-1:0]                  pci_idx,
   input  logic [WIDTH-1:0]                  pci_wdata,
   output logic [WIDTH-1:0]                  pci_rdata,
   input  logic                              cfg_we,
   input  logic                              cfg_en_bit,
   output logic                              mem_en,
   output logic [NUM_DATA_BARS-1:0][MAP_W-1:0] map_hi
);

   localparam logic [IDX_W-1:0] IRQ_IDX = IDX_W'(NUM_DATA_BARS + 1);

   logic [WIDTH-1:0] irq_mask_q;
   logic             mem_en_q;

   for (genvar g = 0; g < NUM_DATA_BARS; g++) begin : g_map
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + 1);
      logic [MAP_W-1:0] map_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_q <= '0;
         else if (host_we && host_idx == MY_IDX)
            map_q <= host_wdata[WIDTH-1:WIN_LOG2];
         else if (pci_we && pci_idx == MY_IDX)
            map_q <= pci_wdata[WIDTH-1:WIN_LOG2];
      end

      assign map_hi[g] = map_q;

      a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (host_we && pci_we && host_idx == MY_IDX && pci_idx == MY_IDX)
         |=> (map_q == $past(host_wdata[WIDTH-1:WIN_LOG2])));

      a_r6_pci_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (pci_we && pci_idx == MY_IDX && !(host_we && host_idx == MY_IDX))
         |=> (map_q == $past(pci_wdata[WIDTH-1:WIN_LOG2])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_mask_q <= '0;
      else if (host_we && host_idx == IRQ_IDX)
         irq_mask_q <= host_wdata;
      else if (pci_we && pci_idx == IRQ_IDX)
         irq_mask_q <= pci_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem_en_q <= 1'b0;
      else if (cfg_we)
         mem_en_q <= cfg_en_bit;
   end

   assign mem_en = mem_en_q;

   always_comb begin
      host_rdata = '0;
      pci_rdata  = '0;
      for (int i = 0; i < NUM_DATA_BARS; i++) begin
         if (host_idx == IDX_W'(i + 1)) host_rdata = {map_hi[i], {WIN_LOG2{1'b0}}};
         if (pci_idx  == IDX_W'(i + 1)) pci_rdata  = {map_hi[i], {WIN_LOG2{1'b0}}};
      end
      if (host_idx == IRQ_IDX) host_rdata = irq_mask_q;
      if (pci_idx  == IRQ_IDX) pci_rdata  = irq_mask_q;
   end

endmodule

// File: rtl/pcibm_xlate.sv
module pcibm_xlate #(
   parameter int WIDTH         = 32,
   parameter int WIN_LOG2      = 16,
   parameter int NUM_DATA_BARS = 4,
   localparam int MAP_W        = WIDTH - WIN_LOG2
) (
   input  logic [NUM_DATA_BARS-1:0][MAP_W-1:0] map_hi,
   input  logic [2:0]                          bar_idx,
   input  logic [WIN_LOG2-1:0]                 offs,
   output logic [WIDTH-1:0]                    bus_addr
);

   logic [MAP_W-1:0] sel_hi;

   always_comb begin
      sel_hi = '0;
      for (int i = 0; i < NUM_DATA_BARS; i++) begin
         if (bar_idx == 3'(i + 1)) sel_hi = map_hi[i];
      end
   end

   assign bus_addr = {sel_hi, offs};

endmodule

// File: rtl/pci_bar_mapper.sv
module pci_bar_mapper
   import pcibm_pkg::*;
#(
   parameter int WIDTH         = 32,
   parameter int WIN_LOG2      = 16,
   parameter int NUM_DATA_BARS = 4,
   parameter int IDX_W         = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [3:0]          req_cmd,
   input  logic [5:0]          req_bar,
   input  logic [WIN_LOG2-1:0] req_offs,
   input  logic [WIDTH-1:0]    req_wdata,
   input  logic                host_we,
   input  logic [IDX_W-1:0]    host_idx,
   input  logic [WIDTH-1:0]    host_wdata,
   output logic [WIDTH-1:0]    host_rdata,
   output logic                claim,
   output logic                fwd_valid,
   output logic                fwd_write,
   output logic [WIDTH-1:0]    fwd_addr,
   output logic                loc_rvalid,
   output logic [WIDTH-1:0]    loc_rdata
);

   localparam int MAP_W = WIDTH - WIN_LOG2;
   localparam logic [5:0] CFG_EN_DW = 6'd1;

   if (WIN_LOG2 < 8 || WIN_LOG2 >= WIDTH) begin : g_chk_win
      $error("WIN_LOG2 must lie in [8, WIDTH-1]");
   end
   if (NUM_DATA_BARS < 1 || NUM_DATA_BARS > 4) begin : g_chk_bars
      $error("NUM_DATA_BARS must lie in [1, 4]");
   end
   if ((NUM_DATA_BARS + 1) >= (1 << IDX_W) || IDX_W > WIN_LOG2 - 2) begin : g_chk_idx
      $error("IDX_W too narrow for the register file or too wide for the window");
   end

   acc_kind_e                        kind;
   logic [2:0]                       bar_idx;
   logic                             is_wr;
   logic                             mem_en;
   logic [NUM_DATA_BARS-1:0][MAP_W-1:0] map_hi;
   logic [WIDTH-1:0]                 pci_rdata;
   logic [WIDTH-1:0]                 bus_addr;
   logic [IDX_W-1:0]                 pci_idx;
   logic                             cfg_hit_en;
   logic                             pci_we;
   logic                             cfg_we;

   pcibm_decode #(
      .NUM_DATA_BARS(NUM_DATA_BARS)
   ) u_decode (
      .req_valid(req_valid),
      .req_cmd  (req_cmd),
      .req_bar  (req_bar),
      .mem_en   (mem_en),
      .kind     (kind),
      .bar_idx  (bar_idx),
      .is_wr    (is_wr)
   );

   assign pci_idx    = req_offs[IDX_W+1:2];
   assign cfg_hit_en = (req_offs[7:2] == CFG_EN_DW);
   assign pci_we     = (kind == ACC_LOCAL) && is_wr;
   assign cfg_we     = (kind == ACC_CFG) && is_wr && cfg_hit_en;

   pcibm_regfile #(
      .WIDTH        (WIDTH),
      .WIN_LOG2     (WIN_LOG2),
      .NUM_DATA_BARS(NUM_DATA_BARS),
      .IDX_W        (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .host_idx  (host_idx),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .pci_we    (pci_we),
      .pci_idx   (pci_idx),
      .pci_wdata (req_wdata),
      .pci_rdata (pci_rdata),
      .cfg_we    (cfg_we),
      .cfg_en_bit(req_wdata[1]),
      .mem_en    (mem_en),
      .map_hi    (map_hi)
   );

   pcibm_xlate #(
      .WIDTH        (WIDTH),
      .WIN_LOG2     (WIN_LOG2),
      .NUM_DATA_BARS(NUM_DATA_BARS)
   ) u_xlate (
      .map_hi  (map_hi),
      .bar_idx (bar_idx),
      .offs    (req_offs),
      .bus_addr(bus_addr)
   );

   logic [WIDTH-1:0] cfg_rdata;
   always_comb begin
      cfg_rdata = '0;
      if (cfg_hit_en) cfg_rdata[1] = mem_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         claim      <= 1'b0;
         fwd_valid  <= 1'b0;
         fwd_write  <= 1'b0;
         fwd_addr   <= '0;
         loc_rvalid <= 1'b0;
         loc_rdata  <= '0;
      end else begin
         claim      <= (kind != ACC_NONE);
         fwd_valid  <= (kind == ACC_FWD);
         loc_rvalid <= ((kind == ACC_LOCAL) || (kind == ACC_CFG)) && !is_wr;
         if (kind == ACC_FWD) begin
            fwd_addr  <= bus_addr;
            fwd_write <= is_wr;
         end
         if (kind == ACC_LOCAL && !is_wr)
            loc_rdata <= pci_rdata;
         else if (kind == ACC_CFG && !is_wr)
            loc_rdata <= cfg_rdata;
      end
   end

   a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_en && is_mem_cmd(req_cmd)) |=> (!claim && !fwd_valid));

   a_r3_fwd_is_claimed: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> claim);

   a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_addr[WIN_LOG2-1:0] == $past(req_offs)));

   a_r5_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_mem_cmd(req_cmd) && !is_cfg_cmd(req_cmd)) |=> (!claim && !fwd_valid));

   a_r6_win0_local: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mem_en && is_mem_cmd(req_cmd) && req_bar == 6'b000001) |=> (claim && !fwd_valid));

   a_r7_win5_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_mem_cmd(req_cmd) && req_bar == 6'b100000) |=> (!claim && !fwd_valid));

   a_r8_cfg_local: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_cfg_cmd(req_cmd)) |=> (claim && !fwd_valid));

   a_r11_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_mem_cmd(req_cmd) && $countones(req_bar) > 1) |=> (!claim && !fwd_valid));

endmodule

// File: tb/pci_bar_mapper_bench.sv
`timescale 1ns/1ps
module pci_bar_mapper_bench;

   localparam int W  = 32;
   localparam int N  = 16;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_cmd = '0;
   logic [5:0]    req_bar = '0;
   logic [N-1:0]  req_offs = '0;
   logic [W-1:0]  req_wdata = '0;
   logic          host_we = 1'b0;
   logic [IW-1:0] host_idx = '0;
   logic [W-1:0]  host_wdata = '0;
   logic [W-1:0]  host_rdata;
   logic          claim, fwd_valid, fwd_write, loc_rvalid;
   logic [W-1:0]  fwd_addr, loc_rdata;

   int n_chk = 0;
   int n_bad = 0;

   logic          o_claim, o_fwd, o_fwr, o_rv;
   logic [W-1:0]  o_addr, o_rd;
   logic [W-1:0]  map_exp [1:4];

   always #5 clk = ~clk;

   pci_bar_mapper u_pci_bar_mapper (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_bar(req_bar),
      .req_offs(req_offs), .req_wdata(req_wdata),
      .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .claim(claim), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
      .fwd_addr(fwd_addr), .loc_rvalid(loc_rvalid), .loc_rdata(loc_rdata)
   );

   task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pci(input logic [3:0] cmd, input logic [5:0] bar,
                      input logic [N-1:0] offs, input logic [W-1:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = cmd; req_bar = bar; req_offs = offs; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      o_claim = claim; o_fwd = fwd_valid; o_fwr = fwd_write;
      o_addr = fwd_addr; o_rv = loc_rvalid; o_rd = loc_rdata;
   endtask

   task automatic host_wr(input logic [IW-1:0] idx, input logic [W-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_idx = idx; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [IW-1:0] idx, output logic [W-1:0] d);
      @(negedge clk);
      host_idx = idx;
      #1 d = host_rdata;
   endtask

   task automatic t_reset;
      logic [W-1:0] d;
      chk(!claim && !fwd_valid && !loc_rvalid, "R1 outputs idle", {29'd0, claim, fwd_valid, loc_rvalid}, '0);
      for (int i = 1; i <= 5; i++) begin
         host_rd(IW'(i), d);
         chk(d == '0, "R1 register reset", d, '0);
      end
      pci(4'hA, 6'b0, 16'h0004, '0);
      chk(o_rv && o_rd == '0, "R1 enable clear", o_rd, '0);
   endtask

   task automatic t_disabled;
      logic [W-1:0] d;
      pci(4'h6, 6'b000010, 16'h0010, '0);
      chk(!o_claim && !o_fwd, "R2 disabled read", {30'd0, o_claim, o_fwd}, '0);
      pci(4'h7, 6'b000001, 16'h0004, 32'hDEAD_0000);
      chk(!o_claim, "R2 disabled window0 write", {31'd0, o_claim}, '0);
      host_rd(3'd1, d);
      chk(d == '0, "R2 register untouched", d, '0);
   endtask

   task automatic t_cfg;
      pci(4'hB, 6'b0, 16'h0004, 32'h0000_0002);
      chk(o_claim && !o_fwd && !o_rv, "R8 cfg write claimed", {29'd0, o_claim, o_fwd, o_rv}, 32'h4);
      pci(4'hA, 6'b0, 16'h0004, '0);
      chk(o_claim && !o_fwd && o_rv && o_rd == 32'h2, "R8 cfg read enable", o_rd, 32'h2);
      pci(4'hA, 6'b0, 16'h0008, '0);
      chk(o_rv && o_rd == '0, "R8 cfg read other offset", o_rd, '0);
   endtask

   task automatic t_host_prog;
      logic [W-1:0] d;
      for (int k = 1; k <= 4; k++) begin
         host_wr(IW'(k), 32'hA000_FFFF + (k << 20));
         map_exp[k] = (32'hA000_0000 + (k << 20));
         host_rd(IW'(k), d);
         chk(d == map_exp[k], "R9 host readback", d, map_exp[k]);
      end
   endtask

   task automatic t_fwd;
      logic [3:0] cmds [3];
      cmds[0] = 4'h6; cmds[1] = 4'hC; cmds[2] = 4'h7;
      for (int k = 1; k <= 4; k++) begin
         for (int c = 0; c < 3; c++) begin
            logic [N-1:0] off;
            logic [W-1:0] ea;
            off = N'(16'h1000 * k + 16'h0100 * c + 16'h0023);
            ea  = {map_exp[k][W-1:N], off};
            pci(cmds[c], 6'(1 << k), off, '0);
            chk(o_claim && o_fwd, "R3 claim and forward", {30'd0, o_claim, o_fwd}, 32'h3);
            chk(o_fwr == (cmds[c] == 4'h7), "R3 write flag", {31'd0, o_fwr}, {31'd0, cmds[c] == 4'h7});
            chk(o_addr == ea, "R4 relocated address", o_addr, ea);
            @(negedge clk);
            chk(!fwd_valid && !claim, "R3 single-cycle strobe", {30'd0, claim, fwd_valid}, '0);
         end
      end
   endtask

   task automatic t_ignored;
      logic [3:0] bad [5];
      logic [W-1:0] d;
      bad[0] = 4'h2; bad[1] = 4'h3; bad[2] = 4'hE; bad[3] = 4'h0; bad[4] = 4'hF;
      for (int i = 0; i < 5; i++) begin
         pci(bad[i], 6'b000010, 16'h0040, '0);
         chk(!o_claim && !o_fwd, "R5 unsupported command", {30'd0, o_claim, o_fwd}, '0);
      end
      pci(4'h3, 6'b000001, 16'h0004, 32'h1234_0000);
      host_rd(3'd1, d);
      chk(d == map_exp[1], "R5 register unchanged", d, map_exp[1]);
   endtask

   task automatic t_win0;
      logic [W-1:0] d;
      pci(4'h7, 6'b000001, 16'h0008, 32'hBEEF_1234);
      chk(o_claim && !o_fwd, "R6 window0 write local", {30'd0, o_claim, o_fwd}, 32'h2);
      map_exp[2] = 32'hBEEF_0000;
      host_rd(3'd2, d);
      chk(d == 32'hBEEF_0000, "R6 window0 write lands", d, 32'hBEEF_0000);
      pci(4'h6, 6'b000001, 16'h0008, '0);
      chk(o_rv && o_rd == 32'hBEEF_0000, "R6 window0 read", o_rd, 32'hBEEF_0000);
      pci(4'h6, 6'b000100, 16'h0042, '0);
      chk(o_addr == 32'hBEEF_0042, "R4 new relocation used", o_addr, 32'hBEEF_0042);
      pci(4'h7, 6'b000001, 16'h0014, 32'h0000_00FF);
      host_rd(3'd5, d);
      chk(d == 32'h0000_00FF, "R6 interrupt mask", d, 32'hFF);
   endtask

   task automatic t_win5_multi;
      pci(4'h6, 6'b100000, 16'h0010, '0);
      chk(!o_claim && !o_fwd, "R7 window5 silent", {30'd0, o_claim, o_fwd}, '0);
      pci(4'h7, 6'b100000, 16'h0010, '0);
      chk(!o_claim && !o_fwd, "R7 window5 write silent", {30'd0, o_claim, o_fwd}, '0);
      pci(4'h6, 6'b000110, 16'h0010, '0);
      chk(!o_claim && !o_fwd, "R11 multiple hits", {30'd0, o_claim, o_fwd}, '0);
   endtask

   task automatic t_collision;
      logic [W-1:0] d;
      @(negedge clk);
      host_we = 1'b1; host_idx = 3'd3; host_wdata = 32'h5555_0000;
      req_valid = 1'b1; req_cmd = 4'h7; req_bar = 6'b000001;
      req_offs = 16'h000C; req_wdata = 32'h6666_0000;
      @(negedge clk);
      host_we = 1'b0; req_valid = 1'b0;
      host_rd(3'd3, d);
      chk(d == 32'h5555_0000, "R10 host wins same register", d, 32'h5555_0000);
      @(negedge clk);
      host_we = 1'b1; host_idx = 3'd1; host_wdata = 32'h7777_0000;
      req_valid = 1'b1; req_cmd = 4'h7; req_bar = 6'b000001;
      req_offs = 16'h0010; req_wdata = 32'h8888_0000;
      @(negedge clk);
      host_we = 1'b0; req_valid = 1'b0;
      host_rd(3'd1, d);
      chk(d == 32'h7777_0000, "R10 host write lands", d, 32'h7777_0000);
      pci(4'h6, 6'b010000, 16'h0001, '0);
      chk(o_addr == 32'h8888_0001, "R10 window0 write lands", o_addr, 32'h8888_0001);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_cfg();
      t_host_prog();
      t_fwd();
      t_ignored();
      t_win0();
      t_win5_multi();
      t_collision();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule